// File: doc/BRIEF.md
# Sync-Tagged Packet Parser with CRC-12 Check

This block sits on the receive side of a serial link, right after the deserializer. Each cycle of the recovered word clock it samples a 12-bit word and two tag strobes. One strobe marks the word as a device identifier. The other marks it as a check word. Packet boundaries come only from these tags; there is no length field. The parser rebuilds each packet from them. It reports the identifier once, passes the frame words on as a stream with first-word and last-word markers, and recomputes a CRC-12 over the identifier and frame words. At the close of each packet it gives a one-cycle good or bad verdict.

The last frame word of a packet is only known once the check word arrives. For this reason the payload stream runs one word behind the input. The end marker then falls on the correct word, in the same cycle as the verdict. Packets that are cut short by a new identifier, and check words that arrive with no packet open, are counted in a saturating protocol-error counter.

Top module: `stream_frame_parser`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `id_valid`, `pay_valid`, `pay_sop`, `pay_eop` and `stat_valid` are low and `err_count` is zero.
- R2: A word sampled with `tag_id` high is an identifier. It opens a new packet, and one cycle later `id_valid` pulses for one cycle with `id_word` equal to that word. When `tag_id` and `tag_crc` are both high, the word is treated as an identifier.
- R3: A word sampled with both tags low while a packet is open is a frame word. Frame words leave on `pay_data` in arrival order. Each one is emitted one cycle after the next word of the packet is sampled. The first frame word of a packet carries `pay_sop`.
- R4: A word sampled with both tags low while no packet is open produces no output, and `err_count` does not change.
- R5: The check value is a CRC-12 with generator x^12+x^11+x^3+x^2+x+1 (0x80F) and a zero initial value. It is computed most-significant bit first over the identifier and then each frame word.
- R6: A word sampled with `tag_crc` high (and `tag_id` low) while a packet is open closes the packet. One cycle later `stat_valid` pulses with `stat_good` high exactly when the word equals the computed CRC. In that same cycle the held last frame word, if any, appears with `pay_eop` high.
- R7: A packet with no frame words (identifier followed directly by a check word) produces the verdict pulse with `pay_valid` low.
- R8: An identifier that arrives while a packet is open ends the old packet as bad. One cycle later `stat_valid` is high with `stat_good` low, the held frame word (if any) is emitted with `pay_eop`, `err_count` increments, and `id_valid` reports the new identifier.
- R9: A check word sampled while no packet is open produces no stream or verdict output and increments `err_count` one cycle later.
- R10: `err_count` saturates at its all-ones value and never decreases except through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 12 | Incoming data word |
| tag_id | input | 1 | Word is a device identifier |
| tag_crc | input | 1 | Word is the packet check value |
| id_valid | output | 1 | One-cycle pulse: new identifier accepted |
| id_word | output | 12 | Identifier of the packet just opened |
| pay_valid | output | 1 | Frame word present on `pay_data` |
| pay_data | output | 12 | Frame word |
| pay_sop | output | 1 | First frame word of the packet |
| pay_eop | output | 1 | Last frame word of the packet |
| stat_valid | output | 1 | One-cycle packet verdict pulse |
| stat_good | output | 1 | Verdict: check value matched |
| err_count | output | ERR_W | Saturating protocol-error count |

## Verification
Errors in the open/closed state appear within one cycle. They show up as idle words leaking onto `pay_valid`, as missing verdicts, or as `err_count` moving on words that should leave it alone. A wrong CRC register only shows when the next check word arrives, as a flipped `stat_good`. The bench therefore mixes short, empty and long packets with corrupted check words. A hold-back register that slips by a word shows at once as misplaced `pay_sop`/`pay_eop` markers or shifted `pay_data` values. The per-cycle comparison catches these in the cycle they occur.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  localparam int unsigned WORD_W   = 12;
  localparam logic [WORD_W-1:0] CRC_POLY = 12'h80F;
  localparam logic [WORD_W-1:0] CRC_SEED = 12'h000;

  // Advance the CRC register by one full word, most significant bit first.
  function automatic logic [WORD_W-1:0] crc_word_step(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] din
  );
    logic [WORD_W-1:0] c;
    logic              fb;
    c = cur;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = c[WORD_W-1] ^ din[i];
      c  = {c[WORD_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/sfp_crc_acc.sv
module sfp_crc_acc
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] crc
);

  logic [WORD_W-1:0] crc_q;
  logic [WORD_W-1:0] crc_d;
  logic              crc_en;

  always_comb begin
    crc_en = restart | advance;
    if (restart) crc_d = crc_word_step(CRC_SEED, din);
    else         crc_d = crc_word_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/sfp_err_cnt.sv
module sfp_err_cnt #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [ERR_W-1:0] count
);

  localparam logic [ERR_W-1:0] TOP = {ERR_W{1'b1}};

  logic [ERR_W-1:0] cnt_q;
  logic [ERR_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = bump && (cnt_q != TOP);
    cnt_d  = cnt_q + {{(ERR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/sfp_framer.sv
module sfp_framer
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              tag_id,
  input  logic              tag_crc,
  input  logic [WORD_W-1:0] crc_now,
  output logic              crc_restart,
  output logic              crc_advance,
  output logic              err_bump,
  output logic              id_valid,
  output logic [WORD_W-1:0] id_word,
  output logic              pay_valid,
  output logic [WORD_W-1:0] pay_data,
  output logic              pay_sop,
  output logic              pay_eop,
  output logic              stat_valid,
  output logic              stat_good
);

  // packet tracking
  logic              open_q, open_d;
  logic              hold_vld_q, hold_vld_d;
  logic              hold_first_q, hold_first_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  // output registers
  logic              idv_q, idv_d;
  logic [WORD_W-1:0] idw_q, idw_d;
  logic              pv_q, pv_d;
  logic [WORD_W-1:0] pd_q, pd_d;
  logic              ps_q, ps_d;
  logic              pe_q, pe_d;
  logic              sv_q, sv_d;
  logic              sg_q, sg_d;
  logic              hold_en;
  logic              pd_en;
  logic              idw_en;

  always_comb begin
    open_d       = open_q;
    hold_vld_d   = hold_vld_q;
    hold_first_d = hold_first_q;
    hold_d       = hold_q;
    idv_d        = 1'b0;
    idw_d        = idw_q;
    pv_d         = 1'b0;
    pd_d         = pd_q;
    ps_d         = 1'b0;
    pe_d         = 1'b0;
    sv_d         = 1'b0;
    sg_d         = 1'b0;
    crc_restart  = 1'b0;
    crc_advance  = 1'b0;
    err_bump     = 1'b0;

    if (tag_id) begin
      // identifier: always opens a packet, truncating any open one
      idv_d       = 1'b1;
      idw_d       = rx_word;
      crc_restart = 1'b1;
      if (open_q) begin
        err_bump = 1'b1;
        sv_d     = 1'b1;
        sg_d     = 1'b0;
        if (hold_vld_q) begin
          pv_d = 1'b1;
          pd_d = hold_q;
          ps_d = hold_first_q;
          pe_d = 1'b1;
        end
      end
      open_d     = 1'b1;
      hold_vld_d = 1'b0;
    end else if (tag_crc) begin
      if (open_q) begin
        sv_d = 1'b1;
        sg_d = (crc_now == rx_word);
        if (hold_vld_q) begin
          pv_d = 1'b1;
          pd_d = hold_q;
          ps_d = hold_first_q;
          pe_d = 1'b1;
        end
        open_d     = 1'b0;
        hold_vld_d = 1'b0;
      end else begin
        err_bump = 1'b1;
      end
    end else if (open_q) begin
      // frame word: release the previous one, keep this one back
      crc_advance = 1'b1;
      if (hold_vld_q) begin
        pv_d = 1'b1;
        pd_d = hold_q;
        ps_d = hold_first_q;
      end
      hold_d       = rx_word;
      hold_vld_d   = 1'b1;
      hold_first_d = !hold_vld_q;
    end
  end

  always_comb begin
    hold_en = open_q && !tag_id && !tag_crc;
    pd_en   = pv_d;
    idw_en  = idv_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      hold_vld_q <= 1'b0;
      idv_q      <= 1'b0;
      pv_q       <= 1'b0;
      ps_q       <= 1'b0;
      pe_q       <= 1'b0;
      sv_q       <= 1'b0;
      sg_q       <= 1'b0;
    end else begin
      open_q     <= open_d;
      hold_vld_q <= hold_vld_d;
      idv_q      <= idv_d;
      pv_q       <= pv_d;
      ps_q       <= ps_d;
      pe_q       <= pe_d;
      sv_q       <= sv_d;
      sg_q       <= sg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q       <= '0;
      hold_first_q <= 1'b0;
    end else if (hold_en) begin
      hold_q       <= hold_d;
      hold_first_q <= hold_first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pd_q <= '0;
    else if (pd_en) pd_q <= pd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idw_q <= '0;
    else if (idw_en) idw_q <= idw_d;
  end

  assign id_valid   = idv_q;
  assign id_word    = idw_q;
  assign pay_valid  = pv_q;
  assign pay_data   = pd_q;
  assign pay_sop    = ps_q;
  assign pay_eop    = pe_q;
  assign stat_valid = sv_q;
  assign stat_good  = sg_q;

endmodule

// File: rtl/stream_frame_parser.sv
module stream_frame_parser
  import sfp_pkg::*;
#(
  parameter int unsigned ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              tag_id,
  input  logic              tag_crc,
  output logic              id_valid,
  output logic [WORD_W-1:0] id_word,
  output logic              pay_valid,
  output logic [WORD_W-1:0] pay_data,
  output logic              pay_sop,
  output logic              pay_eop,
  output logic              stat_valid,
  output logic              stat_good,
  output logic [ERR_W-1:0]  err_count
);

  logic              crc_restart;
  logic              crc_advance;
  logic              err_bump;
  logic [WORD_W-1:0] crc_now;

  sfp_framer u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_word    (rx_word),
    .tag_id     (tag_id),
    .tag_crc    (tag_crc),
    .crc_now    (crc_now),
    .crc_restart(crc_restart),
    .crc_advance(crc_advance),
    .err_bump   (err_bump),
    .id_valid   (id_valid),
    .id_word    (id_word),
    .pay_valid  (pay_valid),
    .pay_data   (pay_data),
    .pay_sop    (pay_sop),
    .pay_eop    (pay_eop),
    .stat_valid (stat_valid),
    .stat_good  (stat_good)
  );

  sfp_crc_acc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(crc_restart),
    .advance(crc_advance),
    .din    (rx_word),
    .crc    (crc_now)
  );

  sfp_err_cnt #(.ERR_W(ERR_W)) u_err (
    .clk  (clk),
    .rst_n(rst_n),
    .bump (err_bump),
    .count(err_count)
  );

endmodule

// File: rtl/sfp_checker.sv
module sfp_checker
  import sfp_pkg::*;
#(
  parameter int unsigned ERR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] rx_word,
  input logic              tag_id,
  input logic              tag_crc,
  input logic              id_valid,
  input logic [WORD_W-1:0] id_word,
  input logic              pay_valid,
  input logic              pay_sop,
  input logic              pay_eop,
  input logic              stat_valid,
  input logic [ERR_W-1:0]  err_count
);

  // R2
  id_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> ($past(tag_id) && id_word == $past(rx_word)));

  // R3
  marker_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_sop || pay_eop) |-> pay_valid);

  // R6
  verdict_marks_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && pay_valid) |-> pay_eop);

  // R6
  verdict_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ($past(tag_crc) || $past(tag_id)));

  // R6
  end_has_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_eop |-> stat_valid);

  // R10
  err_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count - $past(err_count)) <= ERR_W'(1));

endmodule

bind stream_frame_parser sfp_checker #(.ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_word   (rx_word),
  .tag_id    (tag_id),
  .tag_crc   (tag_crc),
  .id_valid  (id_valid),
  .id_word   (id_word),
  .pay_valid (pay_valid),
  .pay_sop   (pay_sop),
  .pay_eop   (pay_eop),
  .stat_valid(stat_valid),
  .err_count (err_count)
);

// File: tb/stream_frame_parser_tb_top.sv
`timescale 1ns/1ps
module stream_frame_parser_tb_top;

  localparam int ERR_W = 8;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  logic             clk;
  logic             rst_n;
  logic [11:0]      rx_word;
  logic             tag_id;
  logic             tag_crc;
  logic             id_valid;
  logic [11:0]      id_word;
  logic             pay_valid;
  logic [11:0]      pay_data;
  logic             pay_sop;
  logic             pay_eop;
  logic             stat_valid;
  logic             stat_good;
  logic [ERR_W-1:0] err_count;

  stream_frame_parser #(.ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .tag_id(tag_id), .tag_crc(tag_crc),
    .id_valid(id_valid), .id_word(id_word), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_sop(pay_sop), .pay_eop(pay_eop), .stat_valid(stat_valid), .stat_good(stat_good),
    .err_count(err_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  bit      m_open;
  int      m_words[$];     // identifier + frame words of the open packet
  int      m_held[$];      // frame words not yet emitted (at most one)
  bit      m_first_pending;
  int      m_err;
  // expected outputs for the next compare
  bit e_idv; int e_idw; bit e_pv; int e_pd; bit e_ps; bit e_pe; bit e_sv; bit e_sg;
  int last_idw;

  // CRC-12, generator 0x80F, zero start, bit-serial over a word list (R5)
  function automatic int crc_of(int words[$]);
    int r = 0;
    foreach (words[k]) begin
      for (int b = 11; b >= 0; b--) begin
        int top = ((r >> 11) & 1) ^ ((words[k] >> b) & 1);
        r = (r << 1) & 12'hFFF;
        if (top != 0) r = r ^ 12'h80F;
      end
    end
    return r;
  endfunction

  task automatic compare(string req);
    bit ok;
    ok = (id_valid == e_idv) && (id_word == 12'(last_idw)) &&
         (pay_valid == e_pv) && (!e_pv || (pay_data == 12'(e_pd) && pay_sop == e_ps && pay_eop == e_pe)) &&
         (e_pv || (!pay_sop && !pay_eop)) &&
         (stat_valid == e_sv) && (!e_sv || stat_good == e_sg) &&
         (int'(err_count) == m_err);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t got idv=%0b id=%h pv=%0b pd=%h sop=%0b eop=%0b sv=%0b sg=%0b err=%0d exp idv=%0b id=%h pv=%0b pd=%h sop=%0b eop=%0b sv=%0b sg=%0b err=%0d",
               req, $time, id_valid, id_word, pay_valid, pay_data, pay_sop, pay_eop, stat_valid, stat_good, err_count,
               e_idv, last_idw[11:0], e_pv, e_pd[11:0], e_ps, e_pe, e_sv, e_sg, m_err);
    end
  endtask

  function automatic void emit_held(bit last);
    if (m_held.size() > 0) begin
      e_pv = 1; e_pd = m_held.pop_front(); e_ps = m_first_pending; e_pe = last;
      m_first_pending = 0;
    end
  endfunction

  // one word: check previous result, drive new word, predict its result
  task automatic put(int w, bit h, bit v, string req);
    @(negedge clk);
    compare(req);
    rx_word = 12'(w); tag_id = h; tag_crc = v;
    e_idv = 0; e_pv = 0; e_ps = 0; e_pe = 0; e_sv = 0; e_sg = 0;
    if (h) begin
      if (m_open) begin
        e_sv = 1; e_sg = 0;
        emit_held(1);
        if (m_err < ERR_MAX) m_err++;
      end
      e_idv = 1; last_idw = w & 12'hFFF;
      m_open = 1; m_words = {}; m_words.push_back(w & 12'hFFF);
      m_held = {}; m_first_pending = 1;
    end else if (v) begin
      if (m_open) begin
        e_sv = 1; e_sg = (crc_of(m_words) == (w & 12'hFFF));
        emit_held(1);
        m_open = 0;
      end else if (m_err < ERR_MAX) m_err++;
    end else if (m_open) begin
      emit_held(0);
      m_held.push_back(w & 12'hFFF);
      m_words.push_back(w & 12'hFFF);
    end
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) put($urandom & 12'hFFF, 0, 0, req);
  endtask

  // full packet with optional CRC corruption
  task automatic packet(int id, int n, bit corrupt, string req);
    int ws[$];
    ws.push_back(id & 12'hFFF);
    put(id, 1, 0, req);
    for (int i = 0; i < n; i++) begin
      int d = $urandom & 12'hFFF;
      ws.push_back(d);
      put(d, 0, 0, req);
    end
    put(crc_of(ws) ^ (corrupt ? 12'h010 : 0), 0, 1, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_word = 0; tag_id = 0; tag_crc = 0;
    m_open = 0; m_err = 0; m_first_pending = 0; last_idw = 0;
    e_idv = 0; e_idw = 0; e_pv = 0; e_pd = 0; e_ps = 0; e_pe = 0; e_sv = 0; e_sg = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    idle(1, "R1 after release");
    idle(6, "R4 idle closed");
    packet(12'h0A5, 3, 0, "R3 R5 R6 good packet");
    packet(12'h3C1, 1, 0, "R3 R6 single word");
    packet(12'h7FF, 4, 1, "R6 corrupted check");
    packet(12'h011, 0, 0, "R7 empty good");
    packet(12'h012, 0, 1, "R7 empty bad");
    // truncated by a new identifier
    put(12'h100, 1, 0, "R8 open");
    put(12'h222, 0, 0, "R8 word");
    put(12'h333, 0, 0, "R8 word");
    packet(12'h101, 2, 0, "R8 cut and reopen");
    // truncation with no frame word held
    put(12'h102, 1, 0, "R8 open empty");
    packet(12'h103, 1, 0, "R8 cut empty");
    // both strobes high is an identifier
    put(12'h055, 1, 1, "R2 both tags");
    put(12'h066, 0, 0, "R2 word");
    put(crc_of('{12'h055, 12'h066}), 0, 1, "R2 close");
    // orphan check words
    put(12'h123, 0, 1, "R9 orphan");
    idle(2, "R4 idle after orphan");
    for (int p = 0; p < 40; p++) packet($urandom, $urandom_range(0, 9), ($urandom_range(0, 3) == 0), "R5 R6 mixed");
    for (int i = 0; i < ERR_MAX + 5; i++) put($urandom, 0, 1, "R10 saturate");
    packet(12'h0F0, 2, 0, "R10 after saturation");
    idle(2, "R10 tail");
    @(negedge clk);
    compare("R6 final");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule